// File: doc/BRIEF.md
# Control-Track Pulse Pattern Shift Register

This block holds an 8-bit pattern of long and short control-track pulses. While a tape plays, or in the alternate search mode, each playback control pulse arrives as a one-cycle strobe with a long/short verdict. When capture is enabled, the register shifts left and the verdict enters the lowest bit. Software can arm a count of eight captures, and a done flag rises when the eighth pulse arrives.

In record mode the same register works as a pattern source. The top bit tells the pulse generator whether the next recorded pulse is long or short. After each recorded pulse the register rotates left, so the pattern replays in a loop. The CPU writes the pattern through a simple write port and reads it back at any time. Writes are locked out while pattern capture is enabled. The block does not measure pulse widths and does not shape the recorded waveform.

Top module: `ctl_pattern_reg`

## Requirements
- R1: After `rst_n` is low, or after a cycle with `stopReq` high, `regRdData` is 8'hFF, `patFlag` is 0, `recLong` is 1 and any armed count is dropped.
- R2: With `detEnable`=1, `indexActive`=0 and `modeSel` set to playback (2'd1) or search (2'd2), a `pbPulse` cycle shifts the register left. Bit 0 takes `pbLong`, where 1 means long and 0 means short. The new value shows one cycle later.
- R3: A `pbPulse` leaves the register unchanged in any of these cases: `detEnable` is 0, `indexActive` is 1, or `modeSel` is idle (2'd0) or record (2'd3).
- R4: A `regWrEn` cycle loads `regWrData` when `detEnable` is 0. It is ignored when `detEnable` is 1.
- R5: An `armWr` pulse in a capturing mode with `detEnable`=1 arms a count. `patFlag` rises together with the register update of the eighth capture after arming, not before. Counting then stops, so later captures do not set the flag again until the count is re-armed.
- R6: `flagClr` clears `patFlag`. If `flagClr` and the eighth capture fall in the same cycle, the flag is set.
- R7: Re-arming during a count restarts it from zero. A capture in the same cycle as `armWr` is not counted. `armWr` is ignored when `detEnable` is 0.
- R8: `recLong` always equals register bit 7. In record mode, a `recDone` cycle rotates the register left, and the old bit 7 enters bit 0. A `regWrEn` in the same cycle takes precedence over the rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stopReq | input | 1 | Synchronous clear for standby, module stop or control-track stop |
| modeSel | input | 2 | 0 idle, 1 playback, 2 search, 3 record |
| detEnable | input | 1 | Pattern capture enable |
| indexActive | input | 1 | Index-signal detection in progress; inhibits capture |
| armWr | input | 1 | One-cycle write of 1 to the start bit |
| flagClr | input | 1 | One-cycle write of 0 to the done flag |
| regWrEn | input | 1 | CPU write strobe for the pattern register |
| regWrData | input | 8 | CPU write data |
| regRdData | output | 8 | Current pattern register contents |
| pbPulse | input | 1 | One-cycle playback control pulse strobe |
| pbLong | input | 1 | Verdict for the pulse: 1 long, 0 short |
| recDone | input | 1 | One-cycle strobe marking the end of a recorded pulse |
| patFlag | output | 1 | Done flag for eight captured pulses |
| recLong | output | 1 | Type of the next recorded pulse: 1 long, 0 short |

## Verification
The assertions check a set of properties on every cycle. One is the shape of each shift and rotation. Others are the stop clear, the write lockout while capture is enabled, and the flag holding until it is cleared. The rule that the strobes never overlap is also checked every cycle. Other behaviour needs the bench's scenarios: the exact eight-pulse count after arming, re-arming in the middle of a count, the set-over-clear collision, and the recorded bit sequence. The bench also sweeps every 8-bit pattern through both the capture path and the replay path.

// File: rtl/ctl_pat_pkg.sv
package ctl_pat_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_PLAY   = 2'd1,
    MODE_SEARCH = 2'd2,
    MODE_REC    = 2'd3
  } ctlMode_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic rotate;
  } patStrobe_t;
endpackage

// File: rtl/ctl_pat_ctrl.sv
module ctl_pat_ctrl
  import ctl_pat_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stopReq,
  input  logic [1:0] modeSel,
  input  logic       detEnable,
  input  logic       indexActive,
  input  logic       armWr,
  input  logic       flagClr,
  input  logic       regWrEn,
  input  logic       pbPulse,
  input  logic       recDone,
  output patStrobe_t strobe,
  output logic       patFlag
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  ctlMode_e mode;
  logic detActive, capture, armHit, setFlag;
  logic armed;
  logic [CW-1:0] pulseCnt;

  assign mode      = ctlMode_e'(modeSel);
  assign detActive = detEnable && (mode == MODE_PLAY || mode == MODE_SEARCH);
  assign capture   = detActive && pbPulse && !indexActive;
  assign armHit    = armWr && detActive;
  assign setFlag   = capture && armed && !armHit && (pulseCnt == LAST);

  always_comb begin
    strobe.load   = regWrEn && !detEnable;
    strobe.shift  = capture;
    strobe.rotate = (mode == MODE_REC) && recDone && !strobe.load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      pulseCnt <= '0;
      patFlag  <= 1'b0;
    end else if (stopReq) begin
      armed    <= 1'b0;
      pulseCnt <= '0;
      patFlag  <= 1'b0;
    end else begin
      if (armHit) begin
        armed    <= 1'b1;
        pulseCnt <= '0;
      end else if (capture && armed) begin
        if (pulseCnt == LAST) begin
          armed    <= 1'b0;
          pulseCnt <= '0;
        end else begin
          pulseCnt <= pulseCnt + 1'b1;
        end
      end
      if (setFlag)      patFlag <= 1'b1;
      else if (flagClr) patFlag <= 1'b0;
    end
  end

  // R6: a clear with no pulse in flight always drops the flag
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flagClr && !pbPulse && !stopReq) |=> !patFlag);
  // R5: once set, the flag stays until cleared or stopped
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (patFlag && !flagClr && !stopReq) |=> patFlag);
  // R5: an unarmed counter never raises the flag
  p_no_set_unarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !patFlag) |=> !patFlag);
  // R8: the strobes that reach the datapath never overlap
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.load, strobe.shift, strobe.rotate}));
endmodule

// File: rtl/ctl_pat_dp.sv
module ctl_pat_dp
  import ctl_pat_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stopReq,
  input  patStrobe_t       strobe,
  input  logic             bitIn,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] patReg
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             patReg <= ALL_ONES;
    else if (stopReq)       patReg <= ALL_ONES;
    else if (strobe.load)   patReg <= wrData;
    else if (strobe.shift)  patReg <= {patReg[WIDTH-2:0], bitIn};
    else if (strobe.rotate) patReg <= {patReg[WIDTH-2:0], patReg[WIDTH-1]};
  end

  // R2: a capture moves every bit up one place and inserts the verdict
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.shift && !stopReq) |=>
      patReg == {$past(patReg[WIDTH-2:0]), $past(bitIn)});
  // R8: a replay step keeps the pattern as a rotation
  p_rotate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.rotate && !stopReq) |=>
      ($countones(patReg) == $countones($past(patReg))) &&
      patReg[0] == $past(patReg[WIDTH-1]));
  // R3: no strobe, no change
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.load && !strobe.shift && !strobe.rotate && !stopReq) |=> $stable(patReg));
endmodule

// File: rtl/ctl_pattern_reg.sv
module ctl_pattern_reg
  import ctl_pat_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stopReq,
  input  logic [1:0]       modeSel,
  input  logic             detEnable,
  input  logic             indexActive,
  input  logic             armWr,
  input  logic             flagClr,
  input  logic             regWrEn,
  input  logic [WIDTH-1:0] regWrData,
  output logic [WIDTH-1:0] regRdData,
  input  logic             pbPulse,
  input  logic             pbLong,
  input  logic             recDone,
  output logic             patFlag,
  output logic             recLong
);
  patStrobe_t strobe;

  ctl_pat_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .stopReq(stopReq), .modeSel(modeSel),
    .detEnable(detEnable), .indexActive(indexActive), .armWr(armWr),
    .flagClr(flagClr), .regWrEn(regWrEn), .pbPulse(pbPulse),
    .recDone(recDone), .strobe(strobe), .patFlag(patFlag)
  );

  ctl_pat_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .stopReq(stopReq), .strobe(strobe),
    .bitIn(pbLong), .wrData(regWrData), .patReg(regRdData)
  );

  assign recLong = regRdData[WIDTH-1];

  // R1: a stop request restores the all-ones pattern and drops the flag
  p_stop_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stopReq |=> (regRdData == {WIDTH{1'b1}}) && !patFlag);
  // R4: a write while capture is enabled leaves the register alone
  p_write_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && detEnable && !pbPulse && !recDone && !stopReq) |=> $stable(regRdData));
endmodule

// File: tb/tb_ctl_pattern_reg.sv
module tb_ctl_pattern_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stopReq = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic       detEnable = 1'b0;
  logic       indexActive = 1'b0;
  logic       armWr = 1'b0;
  logic       flagClr = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       pbPulse = 1'b0;
  logic       pbLong = 1'b0;
  logic       recDone = 1'b0;
  logic       patFlag;
  logic       recLong;

  int checks = 0;
  int errors = 0;

  always #5ns clk = ~clk;

  ctl_pattern_reg dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    armWr = 0; flagClr = 0; regWrEn = 0; pbPulse = 0; recDone = 0; stopReq = 0;
  endtask

  task automatic pulse(logic lng);
    pbPulse = 1; pbLong = lng; tick();
  endtask

  task automatic wr(logic [7:0] d);
    regWrEn = 1; regWrData = d; tick();
  endtask

  initial begin
    #2_000_000ns;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] e;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 reset reg", regRdData, 8'hFF);
    chk("R1 reset flag", {7'd0, patFlag}, 8'h00);
    chk("R1 reset recLong", {7'd0, recLong}, 8'h01);

    // R4 load when capture disabled, R8 replay of every pattern
    modeSel = 2'd3;
    for (int p = 0; p < 256; p++) begin
      wr(8'(p));
      chk("R4 load", regRdData, 8'(p));
      for (int k = 0; k < 8; k++) begin
        chk("R8 recLong", {7'd0, recLong}, {7'd0, p[7-k]});
        recDone = 1; tick();
      end
      chk("R8 full rotation", regRdData, 8'(p));
    end
    // R8 write beats rotate
    wr(8'h81);
    regWrEn = 1; regWrData = 8'h3C; recDone = 1; tick();
    chk("R8 write over rotate", regRdData, 8'h3C);

    // R2/R5 capture every pattern in playback with an armed count
    modeSel = 2'd1; detEnable = 1;
    for (int p = 0; p < 256; p++) begin
      armWr = 1; tick();
      for (int k = 0; k < 8; k++) begin
        if (k == 7) chk("R5 flag before eighth", {7'd0, patFlag}, 8'h00);
        pulse(p[7-k]);
      end
      chk("R2 captured pattern", regRdData, 8'(p));
      chk("R5 flag on eighth", {7'd0, patFlag}, 8'h01);
      flagClr = 1; tick();
      chk("R6 flag cleared", {7'd0, patFlag}, 8'h00);
    end

    // R5 no further counting after completion
    for (int k = 0; k < 8; k++) pulse(1'b0);
    chk("R5 unarmed no flag", {7'd0, patFlag}, 8'h00);

    // R2 search mode shift
    modeSel = 2'd2;
    pulse(1'b1);
    chk("R2 search shift", regRdData, 8'h01);

    // R4 write ignored while capture enabled
    wr(8'hA5);
    chk("R4 write locked", regRdData, 8'h01);

    // R3 inhibits
    e = regRdData;
    indexActive = 1; pulse(1'b1); indexActive = 0;
    chk("R3 index inhibit", regRdData, e);
    detEnable = 0; pulse(1'b1);
    chk("R3 disabled", regRdData, e);
    detEnable = 1; modeSel = 2'd0; pulse(1'b1);
    chk("R3 idle mode", regRdData, e);
    modeSel = 2'd3; pulse(1'b1);
    chk("R3 record mode", regRdData, e);

    // R6 set wins over clear
    modeSel = 2'd1;
    armWr = 1; tick();
    for (int k = 0; k < 7; k++) pulse(1'b1);
    flagClr = 1; pulse(1'b0);
    chk("R6 set wins", {7'd0, patFlag}, 8'h01);
    flagClr = 1; tick();

    // R7 re-arm restarts count; capture with arm not counted
    armWr = 1; tick();
    for (int k = 0; k < 5; k++) pulse(1'b1);
    armWr = 1; pulse(1'b1);
    for (int k = 0; k < 7; k++) pulse(1'b0);
    chk("R7 re-arm not yet", {7'd0, patFlag}, 8'h00);
    pulse(1'b0);
    chk("R7 re-arm done", {7'd0, patFlag}, 8'h01);
    flagClr = 1; tick();
    // R7 arm ignored while disabled
    detEnable = 0; armWr = 1; tick(); detEnable = 1;
    for (int k = 0; k < 8; k++) pulse(1'b1);
    chk("R7 arm ignored", {7'd0, patFlag}, 8'h00);

    // R1 stop request
    armWr = 1; tick();
    for (int k = 0; k < 8; k++) pulse(1'b0);
    stopReq = 1; tick();
    chk("R1 stop reg", regRdData, 8'hFF);
    chk("R1 stop flag", {7'd0, patFlag}, 8'h00);
    armWr = 1; tick();
    for (int k = 0; k < 7; k++) pulse(1'b0);
    stopReq = 1; tick();
    pulse(1'b0);
    chk("R1 stop drops count", {7'd0, patFlag}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule